// File: doc/BRIEF.md
# Open-Loop Delay-Lock Sequencer

This block sequences the lock of an all-digital delay-locked loop that settles without feedback iteration. After reset, or after a relock request, it runs five fixed steps, one per reference cycle. In order, it enables path selection, pulse-count capture, replica-clock launch, the coarse delay decision and the fine delay decision. It then raises `locked` and freezes both delay codes until the next relock. The lock time is therefore the same at every input frequency, and the codes do not dither once the loop is locked.

The coarse code comes from a time-to-digital sample: a 6-bit thermometer word in which bit 0 is the earliest tap. The word is cleaned by a bubble filter and then converted to a binary tap count. The fine code is a 3-bit successive-approximation result built in a single cycle from three cascaded lead/lag decisions. It is forced to zero when the fine replica already leads the reference.

An edge combiner rebuilds the output clock from separate rise and fall pulses, so the output keeps the duty cycle of the reference.

Top module: `dll_lock_seq`

## Requirements
- R1: While `rst_n` is low, `en_path` is 1 and every other step enable is 0. `locked`, `coarse_code`, `fine_code`, `clk_out` and `pulse_err` are all 0.
- R2: The step enables are one-hot while the sequence runs. Each is high for exactly one cycle, in this order: `en_path`, `en_count`, `en_replica`, `en_coarse`, `en_fine`. Enable bit k of the vector {en_fine,en_coarse,en_replica,en_count,en_path} is high in the k-th cycle after the restart cycle (k = 0 to 4).
- R3: `locked` goes high in the sixth cycle, that is after the fifth rising edge following reset release or following the edge that samples `relock`. While `locked` is high, all step enables are 0.
- R4: At the edge that ends the `en_coarse` cycle, `coarse_code` loads the binary count of the filtered thermometer word's contiguous ones, counted from bit 0 upward. The count is zero-extended to 6 bits.
- R5: Bubble filter: each filtered bit i is the majority of raw bits i-1, i and i+1. Raw bit -1 is taken as 1 and raw bit 6 as 0. For example, 001011 gives 3, 010111 gives 4 and 000101 gives 2.
- R6: If `fine_leads` is 1 at the edge that ends the `en_fine` cycle, `fine_code` loads 000.
- R7: Otherwise `fine_code` loads `lag`. Bit 2 adds half a coarse step, bit 1 a quarter and bit 0 an eighth, and a lag bit of 1 means the replica lags and that weight is added.
- R8: While `locked` is high, `coarse_code` and `fine_code` do not change, whatever the values on `therm`, `lag` and `fine_leads`.
- R9: When `relock` is sampled high, the next cycle shows `locked` 0 and `en_path` 1. This happens even in the middle of a sequence. The old codes stay until their steps decide them again.
- R10: The edge combiner registers its result: one edge after a fall pulse alone, `clk_out` is 0. One edge after a rise pulse alone, `clk_out` is 1. With neither pulse present, `clk_out` holds its level.
- R11: If rise and fall pulses are high together, `clk_out` holds its level and `pulse_err` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| relock | input | 1 | Synchronous restart of the lock sequence |
| therm | input | TW (6) | Sampled thermometer word, bit 0 earliest |
| fine_leads | input | 1 | Fine replica leads the reference at the fine step |
| lag | input | FW (3) | Cascaded lag decisions, bit 2 first |
| rise_pulse | input | 1 | Rising-edge tracing pulse |
| fall_pulse | input | 1 | Falling-edge tracing pulse |
| en_path | output | 1 | Step 1: path selection |
| en_count | output | 1 | Step 2: count capture |
| en_replica | output | 1 | Step 3: replica clock launch |
| en_coarse | output | 1 | Step 4: coarse decision |
| en_fine | output | 1 | Step 5: fine decision |
| coarse_code | output | DW (6) | Binary coarse delay code |
| fine_code | output | FW (3) | Binary fine delay code |
| locked | output | 1 | Lock reached, codes frozen |
| clk_out | output | 1 | Rebuilt output clock |
| pulse_err | output | 1 | Sticky flag for simultaneous pulses |

## Verification
Each step enable is due in the cycle that matches its position after the restart cycle. The lock flag and both codes are due in the fifth cycle after the restart. An edge-combiner result is due one cycle after its pulse.

The driver stamps every expected item with that due cycle, counted from a cycle counter that advances on the rising edge. The monitor compares only the items whose stamp equals the current count, sampling on the falling edge. Frozen-code and held-code checks are stamped at cycles where a wrong design would already have changed them.

// File: rtl/dll_lock_seq.sv
module dll_lock_seq #(
  parameter int TW = 6,
  parameter int DW = 6,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          relock,
  input  logic [TW-1:0] therm,
  input  logic          fine_leads,
  input  logic [FW-1:0] lag,
  input  logic          rise_pulse,
  input  logic          fall_pulse,
  output logic          en_path,
  output logic          en_count,
  output logic          en_replica,
  output logic          en_coarse,
  output logic          en_fine,
  output logic [DW-1:0] coarse_code,
  output logic [FW-1:0] fine_code,
  output logic          locked,
  output logic          clk_out,
  output logic          pulse_err
);
  typedef enum logic [2:0] {
    S_PATH, S_COUNT, S_REPL, S_COARSE, S_FINE, S_LOCK
  } step_t;

  step_t step;
  logic [TW+1:0] ext;
  logic [TW-1:0] filt;
  logic [DW-1:0] run_len;
  logic          run_on;

  assign ext = {1'b0, therm, 1'b1};

  for (genvar i = 0; i < TW; i++) begin : g_maj
    assign filt[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
  end

  always_comb begin
    run_on  = 1'b1;
    run_len = '0;
    for (int i = 0; i < TW; i++) begin
      run_on  = run_on & filt[i];
      run_len = run_len + DW'(run_on);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              step <= S_PATH;
    else if (relock)         step <= S_PATH;
    else if (step != S_LOCK) step <= step_t'(step + 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_code <= '0;
      fine_code   <= '0;
    end else if (!relock) begin
      if (step == S_COARSE) coarse_code <= run_len;
      if (step == S_FINE)   fine_code   <= fine_leads ? '0 : lag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_out   <= 1'b0;
      pulse_err <= 1'b0;
    end else if (rise_pulse && fall_pulse) begin
      pulse_err <= 1'b1;
    end else if (fall_pulse) begin
      clk_out <= 1'b0;
    end else if (rise_pulse) begin
      clk_out <= 1'b1;
    end
  end

  assign en_path    = (step == S_PATH);
  assign en_count   = (step == S_COUNT);
  assign en_replica = (step == S_REPL);
  assign en_coarse  = (step == S_COARSE);
  assign en_fine    = (step == S_FINE);
  assign locked     = (step == S_LOCK);
endmodule

// File: rtl/lock_seq_chk.sv
module lock_seq_chk #(
  parameter int TW = 6,
  parameter int DW = 6,
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          relock,
  input logic [TW-1:0] therm,
  input logic          fine_leads,
  input logic [FW-1:0] lag,
  input logic          rise_pulse,
  input logic          fall_pulse,
  input logic          en_path,
  input logic          en_count,
  input logic          en_replica,
  input logic          en_coarse,
  input logic          en_fine,
  input logic [DW-1:0] coarse_code,
  input logic [FW-1:0] fine_code,
  input logic          locked,
  input logic          clk_out,
  input logic          pulse_err
);
  // R2
  path_to_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_path && !relock) |=> en_count);

  // R3
  fine_to_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fine && !relock) |=> (locked && !en_path && !en_fine));

  // R5
  coarse_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_coarse && !relock) |=> (coarse_code <= DW'(TW)));

  // R6
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fine && fine_leads && !relock) |=> (fine_code == '0));

  // R7
  lag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fine && !fine_leads && !relock) |=> (fine_code == $past(lag)));

  // R8
  frozen_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !relock) |=> ($stable(coarse_code) && $stable(fine_code)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> (en_path && !locked));

  // R10
  fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_pulse && !rise_pulse) |=> !clk_out);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> pulse_err);

  // R11
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_pulse && rise_pulse) |=> ($stable(clk_out) && pulse_err));
endmodule

bind dll_lock_seq lock_seq_chk #(.TW(TW), .DW(DW), .FW(FW)) u_chk (.*);

// File: tb/sim_dll_lock_seq.sv
`timescale 1ns/1ps
module sim_dll_lock_seq;
  logic clk = 1'b0;
  logic rst_n, relock, fine_leads, rise_pulse, fall_pulse;
  logic [5:0] therm;
  logic [2:0] lag;
  logic en_path, en_count, en_replica, en_coarse, en_fine, locked, clk_out, pulse_err;
  logic [5:0] coarse_code;
  logic [2:0] fine_code;

  dll_lock_seq u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    int    due;
    string req;
    int    what;
    int    val;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int prev_c = 0;
  int prev_f = 0;
  string names[6] = '{"enables", "locked", "coarse_code", "fine_code", "clk_out", "pulse_err"};

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic int get(int what);
    case (what)
      0: return int'({en_fine, en_coarse, en_replica, en_count, en_path});
      1: return int'(locked);
      2: return int'(coarse_code);
      3: return int'(fine_code);
      4: return int'(clk_out);
      default: return int'(pulse_err);
    endcase
  endfunction

  task automatic chk(string req, int what, int exp);
    int got;
    got = get(what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, names[what], cyc, got, exp);
    end
  endtask

  task automatic push(int due, string req, int what, int val);
    item_t it;
    it.due = due; it.req = req; it.what = what; it.val = val;
    q.push_back(it);
  endtask

  always @(negedge clk)
    if (rst_n)
      for (int i = q.size() - 1; i >= 0; i--)
        if (q[i].due == cyc) begin
          chk(q[i].req, q[i].what, q[i].val);
          q.delete(i);
        end

  task automatic push_seq(int base, int n, int ec, string ctag, int ef, string ftag);
    for (int k = 0; k < n; k++) begin
      push(base + k, "R2", 0, 1 << k);
      push(base + k, "R3", 1, 0);
    end
    if (n == 5) begin
      push(base + 5, "R3", 0, 0);
      push(base + 5, "R3", 1, 1);
      push(base + 5, ctag, 2, ec);
      push(base + 5, ftag, 3, ef);
    end
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic freeze_check(int base, int ec, int ef);
    wait_cyc(base + 5);
    therm = ~therm; lag = ~lag; fine_leads = ~fine_leads;
    push(base + 7, "R8", 2, ec);
    push(base + 7, "R8", 3, ef);
    push(base + 7, "R8", 1, 1);
    wait_cyc(base + 8);
    prev_c = ec; prev_f = ef;
  endtask

  task automatic relock_run(logic [5:0] t, logic lf, logic [2:0] lg,
                            int ec, string ctag, int ef, string ftag);
    int base;
    @(negedge clk);
    therm = t; fine_leads = lf; lag = lg; relock = 1'b1;
    base = cyc + 1;
    push(base, "R9", 1, 0);
    push(base + 3, "R9", 2, prev_c);
    push(base + 4, "R9", 3, prev_f);
    push_seq(base, 5, ec, ctag, ef, ftag);
    @(negedge clk);
    relock = 1'b0;
    freeze_check(base, ec, ef);
  endtask

  task automatic ec_step(logic r, logic f, int eclk, int eerr, string tag);
    @(negedge clk);
    rise_pulse = r; fall_pulse = f;
    push(cyc + 1, tag, 4, eclk);
    push(cyc + 1, (eerr != 0 || (r && f)) ? "R11" : tag, 5, eerr);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; relock = 1'b0; fine_leads = 1'b0; lag = '0; therm = '0;
    rise_pulse = 1'b0; fall_pulse = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", 0, 1);
    chk("R1", 1, 0);
    chk("R1", 2, 0);
    chk("R1", 3, 0);
    chk("R1", 4, 0);
    chk("R1", 5, 0);

    therm = 6'b011111; fine_leads = 1'b0; lag = 3'b101;
    rst_n = 1'b1;
    push_seq(0, 5, 5, "R4", 5, "R7");
    freeze_check(0, 5, 5);

    relock_run(6'b001011, 1'b1, 3'b111, 3, "R5", 0, "R6");
    relock_run(6'b010111, 1'b0, 3'b010, 4, "R5", 2, "R7");
    relock_run(6'b000101, 1'b0, 3'b011, 2, "R5", 3, "R7");
    relock_run(6'b111111, 1'b0, 3'b000, 6, "R4", 0, "R7");

    // R9 restart in the middle of a sequence
    @(negedge clk);
    relock = 1'b1; base = cyc + 1;
    push_seq(base, 3, 0, "R9", 0, "R9");
    @(negedge clk);
    relock = 1'b0;
    wait_cyc(base + 2);
    relock_run(6'b000000, 1'b0, 3'b111, 0, "R4", 7, "R7");
    relock_run(6'b000111, 1'b1, 3'b000, 3, "R4", 0, "R6");

    // R10 / R11 edge combiner
    ec_step(1'b1, 1'b0, 1, 0, "R10");
    ec_step(1'b0, 1'b0, 1, 0, "R10");
    ec_step(1'b0, 1'b1, 0, 0, "R10");
    ec_step(1'b0, 1'b0, 0, 0, "R10");
    ec_step(1'b1, 1'b1, 0, 1, "R11");
    ec_step(1'b1, 1'b0, 1, 1, "R11");
    ec_step(1'b1, 1'b1, 1, 1, "R11");
    ec_step(1'b0, 1'b1, 0, 1, "R11");
    @(negedge clk);
    rise_pulse = 1'b0; fall_pulse = 1'b0;

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule